// File: doc/BRIEF.md
# I2C Multi-Message Transaction Sequencer

This block drives a byte-level I2C master so that no interrupt handler is needed between bytes. A requester sets up a list of messages and pulses a start request. Each message has a 7-bit target address, a direction, a flag that suppresses its address phase, and a byte length. The sequencer reads the descriptors one at a time through an index port. It takes outgoing bytes from a write stream and hands incoming bytes to a read stream. Each time the byte engine reports that a byte has finished, it issues exactly one new command to that engine.

Messages are linked with a repeated START, unless a message asks to continue the previous one without an address phase. In that case the sequencer goes straight to data. Reads acknowledge every byte except the final byte of the message. A refused address or data byte, or a lost arbitration, makes the sequencer close the bus with STOP and end with an error. When the STOP completes, the sequencer acknowledges the completion event to the byte engine. It then raises a one-clock done or error pulse that carries the number of messages that were fully finished.

Top module: `i2c_xact_seq`

## Requirements
- R1: After reset there is no command, no write pop, no read strobe, no done or error pulse, and `msg_idx` is 0.
- R2: A start request with a nonzero message count, seen while idle, issues a START command (`cmd_op` = 0) one clock later. The command carries the address byte of message 0.
- R3: The address byte is the 7-bit address in bits 7:1, with bit 0 = 1 for a read message and 0 for a write message.
- R4: A completed address or data byte in a write message with bytes still left issues a WRITE command (`cmd_op` = 1). The command carries the current head of the write stream, and `wr_pop` is high in the same clock.
- R5: In a read message, every byte except the last is requested with READ_ACK (`cmd_op` = 2), and the last byte with READ_NACK (`cmd_op` = 3). Each received byte appears on `rd_data` with a one-clock `rd_valid`.
- R6: A NACK reported for an address byte or a written byte issues STOP (`cmd_op` = 4) and leads to the error outcome.
- R7: A lost arbitration reported for any byte of an active transfer issues STOP and leads to the error outcome.
- R8: When a message ends and another follows, the next message begins with a repeated START and its address byte. If the next message has its no-address flag set, its first data command is issued directly.
- R9: A message of length zero ends immediately after its address phase (or at once, if it has no address phase). Processing moves to the next message, or to STOP.
- R10: When the last message ends, STOP is issued. The completion event after any STOP issues IACK (`cmd_op` = 5). In the same clock, a one-clock `xfer_done` (success) or `xfer_err` (failure) pulse appears, with `msgs_done` equal to the number of fully finished messages.
- R11: A start request while a transfer is in progress, a start request with a count of zero, and a byte-done event while idle all produce no command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_req | input | 1 | One-clock request to run a transaction |
| start_cnt | input | IDX_W | Number of messages in the transaction |
| msg_idx | output | IDX_W | Index of the descriptor being read |
| msg_addr | input | 7 | Target address of the indexed message |
| msg_rd | input | 1 | Indexed message is a read |
| msg_nostart | input | 1 | Indexed message continues without an address phase |
| msg_len | input | LEN_W | Byte count of the indexed message |
| wr_data | input | 8 | Head of the outgoing byte stream |
| wr_pop | output | 1 | Head byte consumed this clock |
| rd_data | output | 8 | Received byte |
| rd_valid | output | 1 | `rd_data` is valid this clock |
| cmd_valid | output | 1 | A command is issued to the byte engine |
| cmd_op | output | 3 | Command code: 0 START, 1 WRITE, 2 READ_ACK, 3 READ_NACK, 4 STOP, 5 IACK |
| cmd_byte | output | 8 | Byte sent with START or WRITE |
| evt_done | input | 1 | Byte engine finished its last command |
| evt_nack | input | 1 | Target refused the byte (valid with `evt_done`) |
| evt_arblost | input | 1 | Arbitration lost (valid with `evt_done`) |
| evt_rx | input | 8 | Byte received by a read (valid with `evt_done`) |
| xfer_done | output | 1 | One-clock success pulse |
| xfer_err | output | 1 | One-clock failure pulse |
| msgs_done | output | IDX_W | Messages fully finished, valid with the pulses |

## Verification
A wrong internal state appears at the command port within one or two clocks of the byte-done event that exposed it. Examples are a READ_ACK where READ_NACK is due, a WRITE where a repeated START belongs, or a missing STOP after a NACK. The bench compares every command, one by one, against a sequence it derives itself from the descriptors. A wrong message index shows up at the latest in `msgs_done` on the closing pulse, and earlier in the address byte of the next START. Lost or extra stream traffic shows up as a wrong byte in the next WRITE command, or as a wrong count of read strobes.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;

  typedef enum logic [2:0] {
    SQ_DONE  = 3'd0,
    SQ_START = 3'd1,
    SQ_WRITE = 3'd2,
    SQ_READ  = 3'd3,
    SQ_ERROR = 3'd4
  } seq_state_t;

  typedef enum logic [2:0] {
    OP_START  = 3'd0,
    OP_WRITE  = 3'd1,
    OP_RDACK  = 3'd2,
    OP_RDNACK = 3'd3,
    OP_STOP   = 3'd4,
    OP_IACK   = 3'd5
  } bus_op_t;

  // address byte: target in the upper seven bits, direction in bit 0
  function automatic logic [7:0] addr_byte(input logic [6:0] a, input logic rd);
    return {a, rd};
  endfunction

  // true when the byte at position p is the final one of a message of length l
  function automatic logic is_final(input logic [15:0] p, input logic [15:0] l);
    return (p + 16'd1) == l;
  endfunction

endpackage

// File: rtl/i2c_seq_ctl.sv
module i2c_seq_ctl
  import i2c_seq_pkg::*;
#(
  parameter int IDX_W = 4,
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_req,
  input  logic [IDX_W-1:0] start_cnt,
  input  logic [6:0]       d_addr,
  input  logic             d_rd,
  input  logic             d_nostart,
  input  logic [LEN_W-1:0] d_len,
  input  logic [7:0]       wr_data,
  input  logic             evt_done,
  input  logic             evt_nack,
  input  logic             evt_arblost,
  output logic [IDX_W-1:0] idx_o,
  output logic             stop_wait,
  output logic             iss_valid,
  output bus_op_t          iss_op,
  output logic [7:0]       iss_byte,
  output logic             iss_pop,
  output logic             rd_cap,
  output logic             fin_ok,
  output logic             fin_err
);

  seq_state_t       st, st_n;
  logic             stop_pend, stop_pend_n;
  logic             adv, adv_n;
  logic [IDX_W-1:0] idx, idx_n;
  logic [IDX_W-1:0] nmsg, nmsg_n;
  logic [LEN_W-1:0] pos, pos_n;

  logic             go;
  seq_state_t       gs;
  logic [LEN_W-1:0] gp;

  // named events for the assertions
  logic idle, active, busy_evt;
  assign idle     = ((st == SQ_DONE) || (st == SQ_ERROR)) && !stop_pend;
  assign active   = ((st == SQ_START) || (st == SQ_WRITE) || (st == SQ_READ))
                    && !stop_pend && !adv;
  assign busy_evt = active && evt_done;

  assign idx_o     = idx;
  assign stop_wait = stop_pend;

  always_comb begin
    st_n        = st;
    stop_pend_n = stop_pend;
    adv_n       = adv;
    idx_n       = idx;
    nmsg_n      = nmsg;
    pos_n       = pos;
    iss_valid   = 1'b0;
    iss_op      = OP_STOP;
    iss_byte    = 8'h00;
    iss_pop     = 1'b0;
    rd_cap      = 1'b0;
    fin_ok      = 1'b0;
    fin_err     = 1'b0;
    go          = 1'b0;
    gs          = SQ_WRITE;
    gp          = '0;

    if (idle) begin
      if (start_req && (start_cnt != '0)) begin
        nmsg_n    = start_cnt;
        pos_n     = '0;
        st_n      = SQ_START;
        iss_valid = 1'b1;
        iss_op    = OP_START;
        iss_byte  = addr_byte(d_addr, d_rd);
      end
    end else if (stop_pend) begin
      if (evt_done) begin
        stop_pend_n = 1'b0;
        iss_valid   = 1'b1;
        iss_op      = OP_IACK;
        fin_ok      = (st == SQ_DONE);
        fin_err     = (st == SQ_ERROR);
        idx_n       = '0;
      end
    end else if (adv) begin
      adv_n = 1'b0;
      if (idx == nmsg) begin
        st_n        = SQ_DONE;
        stop_pend_n = 1'b1;
        iss_valid   = 1'b1;
        iss_op      = OP_STOP;
      end else if (!d_nostart) begin
        st_n      = SQ_START;
        iss_valid = 1'b1;
        iss_op    = OP_START;
        iss_byte  = addr_byte(d_addr, d_rd);
      end else begin
        st_n  = d_rd ? SQ_READ : SQ_WRITE;
        pos_n = '0;
        if (d_len == '0) begin
          idx_n = idx + 1'b1;
          adv_n = 1'b1;
        end else begin
          go = 1'b1;
          gs = d_rd ? SQ_READ : SQ_WRITE;
          gp = '0;
        end
      end
    end else if (busy_evt) begin
      if (evt_arblost || (evt_nack && (st != SQ_READ))) begin
        st_n        = SQ_ERROR;
        stop_pend_n = 1'b1;
        iss_valid   = 1'b1;
        iss_op      = OP_STOP;
      end else begin
        gs = (st == SQ_READ) ? SQ_READ : (d_rd ? SQ_READ : SQ_WRITE);
        gp = pos;
        if (st == SQ_READ) begin
          rd_cap = 1'b1;
          gp     = pos + 1'b1;
        end
        st_n  = gs;
        pos_n = gp;
        if (gp == d_len) begin
          idx_n = idx + 1'b1;
          pos_n = '0;
          adv_n = 1'b1;
        end else begin
          go = 1'b1;
        end
      end
    end

    if (go) begin
      iss_valid = 1'b1;
      if (gs == SQ_READ) begin
        iss_op = is_final(16'(gp), 16'(d_len)) ? OP_RDNACK : OP_RDACK;
      end else begin
        iss_op   = OP_WRITE;
        iss_byte = wr_data;
        iss_pop  = 1'b1;
        pos_n    = gp + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= SQ_DONE;
      stop_pend <= 1'b0;
      adv       <= 1'b0;
      idx       <= '0;
      nmsg      <= '0;
      pos       <= '0;
    end else begin
      st        <= st_n;
      stop_pend <= stop_pend_n;
      adv       <= adv_n;
      idx       <= idx_n;
      nmsg      <= nmsg_n;
      pos       <= pos_n;
    end
  end

  // R11: with no start request an idle sequencer stays idle
  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && !start_req) |=> idle);

  // R7: arbitration loss during a transfer ends in the error state awaiting STOP
  p_arb_to_error_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_evt && evt_arblost) |=> (st == SQ_ERROR) && stop_pend);

  // R6: refused address or write byte ends in the error state awaiting STOP
  p_nack_to_error_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_evt && evt_nack && (st != SQ_READ)) |=> (st == SQ_ERROR) && stop_pend);

endmodule

// File: rtl/i2c_seq_cmdreg.sv
module i2c_seq_cmdreg
  import i2c_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       iss_valid,
  input  bus_op_t    iss_op,
  input  logic [7:0] iss_byte,
  input  logic       iss_pop,
  output logic       cmd_valid,
  output bus_op_t    cmd_op,
  output logic [7:0] cmd_byte,
  output logic       wr_pop
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_valid <= 1'b0;
      cmd_op    <= OP_STOP;
      cmd_byte  <= 8'h00;
      wr_pop    <= 1'b0;
    end else begin
      cmd_valid <= iss_valid;
      wr_pop    <= iss_pop;
      if (iss_valid) begin
        cmd_op   <= iss_op;
        cmd_byte <= iss_byte;
      end
    end
  end

  // R4: a write-stream pop only accompanies a WRITE command
  p_pop_is_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pop |-> (cmd_valid && (cmd_op == OP_WRITE)));

endmodule

// File: rtl/i2c_seq_report.sv
module i2c_seq_report #(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_cap,
  input  logic [7:0]       evt_rx,
  input  logic             fin_ok,
  input  logic             fin_err,
  input  logic [IDX_W-1:0] fin_cnt,
  output logic             rd_valid,
  output logic [7:0]       rd_data,
  output logic             xfer_done,
  output logic             xfer_err,
  output logic [IDX_W-1:0] msgs_done
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid  <= 1'b0;
      rd_data   <= 8'h00;
      xfer_done <= 1'b0;
      xfer_err  <= 1'b0;
      msgs_done <= '0;
    end else begin
      rd_valid  <= rd_cap;
      xfer_done <= fin_ok;
      xfer_err  <= fin_err;
      if (rd_cap) rd_data <= evt_rx;
      if (fin_ok || fin_err) msgs_done <= fin_cnt;
    end
  end

  // R10: success and failure are never reported together, and each is one clock
  p_fin_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(xfer_done && xfer_err));
  p_fin_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done || xfer_err) |=> !(xfer_done || xfer_err));

endmodule

// File: rtl/i2c_xact_seq.sv
module i2c_xact_seq
  import i2c_seq_pkg::*;
#(
  parameter int MAX_MSGS = 8,
  parameter int LEN_W    = 8,
  localparam int IDX_W   = $clog2(MAX_MSGS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_req,
  input  logic [IDX_W-1:0] start_cnt,
  output logic [IDX_W-1:0] msg_idx,
  input  logic [6:0]       msg_addr,
  input  logic             msg_rd,
  input  logic             msg_nostart,
  input  logic [LEN_W-1:0] msg_len,
  input  logic [7:0]       wr_data,
  output logic             wr_pop,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  output logic             cmd_valid,
  output logic [2:0]       cmd_op,
  output logic [7:0]       cmd_byte,
  input  logic             evt_done,
  input  logic             evt_nack,
  input  logic             evt_arblost,
  input  logic [7:0]       evt_rx,
  output logic             xfer_done,
  output logic             xfer_err,
  output logic [IDX_W-1:0] msgs_done
);

  logic             iss_valid, iss_pop, rd_cap, fin_ok, fin_err, stop_wait;
  bus_op_t          iss_op, cmd_op_e;
  logic [7:0]       iss_byte;
  logic [IDX_W-1:0] idx;

  i2c_seq_ctl #(.IDX_W(IDX_W), .LEN_W(LEN_W)) u_ctl (
    .clk, .rst_n, .start_req, .start_cnt,
    .d_addr(msg_addr), .d_rd(msg_rd), .d_nostart(msg_nostart), .d_len(msg_len),
    .wr_data, .evt_done, .evt_nack, .evt_arblost,
    .idx_o(idx), .stop_wait,
    .iss_valid, .iss_op, .iss_byte, .iss_pop,
    .rd_cap, .fin_ok, .fin_err
  );

  i2c_seq_cmdreg u_cmd (
    .clk, .rst_n, .iss_valid, .iss_op, .iss_byte, .iss_pop,
    .cmd_valid, .cmd_op(cmd_op_e), .cmd_byte, .wr_pop
  );

  i2c_seq_report #(.IDX_W(IDX_W)) u_rpt (
    .clk, .rst_n, .rd_cap, .evt_rx, .fin_ok, .fin_err, .fin_cnt(idx),
    .rd_valid, .rd_data, .xfer_done, .xfer_err, .msgs_done
  );

  assign msg_idx = idx;
  assign cmd_op  = cmd_op_e;

  // R10: the event closing a STOP brings IACK together with the final report
  p_iack_after_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_wait && evt_done) |=> (cmd_valid && (cmd_op_e == OP_IACK)
                                 && (xfer_done || xfer_err)));

endmodule

// File: tb/i2c_xact_seq_bench.sv
module i2c_xact_seq_bench;

  localparam int IDX_W = 4;
  localparam logic [2:0] C_START = 3'd0, C_WRITE = 3'd1, C_RDACK = 3'd2,
                         C_RDNACK = 3'd3, C_STOP = 3'd4, C_IACK = 3'd5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic             start_req = 1'b0;
  logic [IDX_W-1:0] start_cnt = '0;
  logic [IDX_W-1:0] msg_idx;
  logic [6:0]       msg_addr;
  logic             msg_rd, msg_nostart;
  logic [7:0]       msg_len;
  logic [7:0]       wr_data;
  logic             wr_pop;
  logic [7:0]       rd_data;
  logic             rd_valid;
  logic             cmd_valid;
  logic [2:0]       cmd_op;
  logic [7:0]       cmd_byte;
  logic             evt_done = 1'b0, evt_nack = 1'b0, evt_arblost = 1'b0;
  logic [7:0]       evt_rx = 8'h00;
  logic             xfer_done, xfer_err;
  logic [IDX_W-1:0] msgs_done;

  logic [6:0] d_addr [0:7];
  logic       d_rd   [0:7];
  logic       d_ns   [0:7];
  logic [7:0] d_len  [0:7];

  assign msg_addr    = d_addr[msg_idx[2:0]];
  assign msg_rd      = d_rd[msg_idx[2:0]];
  assign msg_nostart = d_ns[msg_idx[2:0]];
  assign msg_len     = d_len[msg_idx[2:0]];

  function automatic logic [7:0] wb(input int i);
    return 8'(8'h3C + i * 29);
  endfunction

  int wptr = 0;
  int wexp = 0;
  assign wr_data = wb(wptr);
  always @(posedge clk) if (wr_pop) wptr <= wptr + 1;

  int rd_cnt = 0;
  logic [7:0] rd_last = 8'h00;
  always @(posedge clk) if (rd_valid) begin rd_cnt <= rd_cnt + 1; rd_last <= rd_data; end

  int checks = 0;
  int fails  = 0;

  i2c_xact_seq u_i2c_xact_seq (
    .clk, .rst_n, .start_req, .start_cnt, .msg_idx, .msg_addr, .msg_rd,
    .msg_nostart, .msg_len, .wr_data, .wr_pop, .rd_data, .rd_valid,
    .cmd_valid, .cmd_op, .cmd_byte, .evt_done, .evt_nack, .evt_arblost,
    .evt_rx, .xfer_done, .xfer_err, .msgs_done
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic set_msg(input int i, input logic [6:0] a, input logic rd,
                         input logic ns, input logic [7:0] len);
    d_addr[i] = a; d_rd[i] = rd; d_ns[i] = ns; d_len[i] = len;
  endtask

  task automatic kick(input int cnt);
    @(negedge clk);
    start_cnt = IDX_W'(cnt);
    start_req = 1'b1;
    @(negedge clk);
    start_req = 1'b0;
  endtask

  // wait for the next command and compare op (and byte when asked)
  task automatic expect_cmd(input logic [2:0] op, input logic [7:0] b,
                            input logic use_b, input string tag);
    int n;
    n = 0;
    while (!cmd_valid && n < 40) begin
      @(negedge clk);
      n++;
    end
    if (!cmd_valid) begin
      chk(1'b0, {tag, " (no command)"}, 0, {op, b});
    end else begin
      chk((cmd_op == op) && (!use_b || cmd_byte == b), tag,
          {cmd_op, (use_b ? cmd_byte : b)}, {op, b});
      if (op == C_WRITE)
        chk(wr_pop == 1'b1, {tag, " pop"}, wr_pop, 1);
    end
  endtask

  task automatic expect_quiet(input int cyc, input string tag);
    logic seen;
    seen = 1'b0;
    for (int k = 0; k < cyc; k++) begin
      @(negedge clk);
      if (cmd_valid) seen = 1'b1;
    end
    chk(!seen, tag, seen, 0);
  endtask

  task automatic evt(input logic nack, input logic arb, input logic [7:0] rx);
    @(negedge clk); @(negedge clk);
    evt_done = 1'b1; evt_nack = nack; evt_arblost = arb; evt_rx = rx;
    @(negedge clk);
    evt_done = 1'b0; evt_nack = 1'b0; evt_arblost = 1'b0;
  endtask

  task automatic expect_end(input logic ok, input int cnt, input string tag);
    evt(1'b0, 1'b0, 8'h00);
    expect_cmd(C_IACK, 8'h00, 1'b0, {tag, " IACK"});
    chk((xfer_done == ok) && (xfer_err == !ok), {tag, " outcome"},
        {xfer_done, xfer_err}, {ok, !ok});
    chk(msgs_done == IDX_W'(cnt), {tag, " count"}, msgs_done, cnt);
    @(negedge clk);
    chk(!xfer_done && !xfer_err, {tag, " one-clock pulse"}, {xfer_done, xfer_err}, 0);
  endtask

  task automatic t_reset;
    chk(!cmd_valid && !wr_pop && !rd_valid && !xfer_done && !xfer_err && msg_idx == 0,
        "R1 reset outputs", {cmd_valid, wr_pop, rd_valid, xfer_done, xfer_err}, 0);
  endtask

  task automatic t_write;
    set_msg(0, 7'h50, 1'b0, 1'b0, 8'd2);
    kick(1);
    expect_cmd(C_START, 8'hA0, 1'b1, "R2 R3 start write address");
    evt(1'b0, 1'b0, 8'h00);
    expect_cmd(C_WRITE, wb(wexp), 1'b1, "R4 first data byte"); wexp++;
    evt(1'b0, 1'b0, 8'h00);
    expect_cmd(C_WRITE, wb(wexp), 1'b1, "R4 second data byte"); wexp++;
    evt(1'b0, 1'b0, 8'h00);
    expect_cmd(C_STOP, 8'h00, 1'b0, "R10 stop after last message");
    expect_end(1'b1, 1, "R10 write");
  endtask

  task automatic t_read;
    int base;
    base = rd_cnt;
    set_msg(0, 7'h1B, 1'b1, 1'b0, 8'd3);
    kick(1);
    expect_cmd(C_START, 8'h37, 1'b1, "R3 read address bit0");
    evt(1'b0, 1'b0, 8'h00);
    expect_cmd(C_RDACK, 8'h00, 1'b0, "R5 first read ack");
    evt(1'b0, 1'b0, 8'hC1);
    expect_cmd(C_RDACK, 8'h00, 1'b0, "R5 middle read ack");
    evt(1'b0, 1'b0, 8'hC2);
    expect_cmd(C_RDNACK, 8'h00, 1'b0, "R5 last read nack");
    chk(rd_last == 8'hC1, "R5 read byte out", rd_last, 8'hC1);
    evt(1'b0, 1'b0, 8'hC3);
    expect_cmd(C_STOP, 8'h00, 1'b0, "R10 stop after read");
    @(negedge clk);
    chk(rd_cnt - base == 3 && rd_last == 8'hC3, "R5 read strobes",
        {rd_cnt - base, rd_last}, {3, 8'hC3});
    expect_end(1'b1, 1, "R10 read");
  endtask

  task automatic t_chain;
    set_msg(0, 7'h22, 1'b0, 1'b0, 8'd1);
    set_msg(1, 7'h40, 1'b0, 1'b1, 8'd0);
    set_msg(2, 7'h22, 1'b1, 1'b0, 8'd1);
    kick(3);
    expect_cmd(C_START, 8'h44, 1'b1, "R2 chain start");
    evt(1'b0, 1'b0, 8'h00);
    expect_cmd(C_WRITE, wb(wexp), 1'b1, "R4 chain write"); wexp++;
    evt(1'b0, 1'b0, 8'h00);
    expect_cmd(C_START, 8'h45, 1'b1, "R8 R9 repeated start after empty message");
    evt(1'b0, 1'b0, 8'h00);
    expect_cmd(C_RDNACK, 8'h00, 1'b0, "R5 single read nack");
    evt(1'b0, 1'b0, 8'h5E);
    expect_cmd(C_STOP, 8'h00, 1'b0, "R10 chain stop");
    expect_end(1'b1, 3, "R10 chain");
  endtask

  task automatic t_nostart;
    set_msg(0, 7'h10, 1'b0, 1'b0, 8'd1);
    set_msg(1, 7'h11, 1'b0, 1'b1, 8'd1);
    kick(2);
    expect_cmd(C_START, 8'h20, 1'b1, "R3 nostart first address");
    evt(1'b0, 1'b0, 8'h00);
    expect_cmd(C_WRITE, wb(wexp), 1'b1, "R4 nostart msg0 byte"); wexp++;
    evt(1'b0, 1'b0, 8'h00);
    expect_cmd(C_WRITE, wb(wexp), 1'b1, "R8 no address phase"); wexp++;
    evt(1'b0, 1'b0, 8'h00);
    expect_cmd(C_STOP, 8'h00, 1'b0, "R10 nostart stop");
    expect_end(1'b1, 2, "R10 nostart");
  endtask

  task automatic t_addr_nack;
    set_msg(0, 7'h66, 1'b0, 1'b0, 8'd2);
    kick(1);
    expect_cmd(C_START, 8'hCC, 1'b1, "R2 nack test start");
    evt(1'b1, 1'b0, 8'h00);
    expect_cmd(C_STOP, 8'h00, 1'b0, "R6 stop on address nack");
    expect_end(1'b0, 0, "R6 address nack");
  endtask

  task automatic t_data_nack;
    set_msg(0, 7'h10, 1'b0, 1'b0, 8'd1);
    set_msg(1, 7'h2A, 1'b0, 1'b0, 8'd3);
    kick(2);
    expect_cmd(C_START, 8'h20, 1'b1, "R2 data nack start");
    evt(1'b0, 1'b0, 8'h00);
    expect_cmd(C_WRITE, wb(wexp), 1'b1, "R4 data nack msg0"); wexp++;
    evt(1'b0, 1'b0, 8'h00);
    expect_cmd(C_START, 8'h54, 1'b1, "R8 second message start");
    evt(1'b0, 1'b0, 8'h00);
    expect_cmd(C_WRITE, wb(wexp), 1'b1, "R4 data nack msg1"); wexp++;
    evt(1'b1, 1'b0, 8'h00);
    expect_cmd(C_STOP, 8'h00, 1'b0, "R6 stop on data nack");
    expect_end(1'b0, 1, "R6 data nack");
  endtask

  task automatic t_arb;
    set_msg(0, 7'h0F, 1'b1, 1'b0, 8'd2);
    kick(1);
    expect_cmd(C_START, 8'h1F, 1'b1, "R3 arb test address");
    evt(1'b0, 1'b0, 8'h00);
    expect_cmd(C_RDACK, 8'h00, 1'b0, "R5 arb test read");
    evt(1'b0, 1'b1, 8'h00);
    expect_cmd(C_STOP, 8'h00, 1'b0, "R7 stop on arbitration loss");
    expect_end(1'b0, 0, "R7 arbitration");
  endtask

  task automatic t_ignore;
    evt(1'b0, 1'b0, 8'h00);
    expect_quiet(6, "R11 event while idle");
    kick(0);
    expect_quiet(6, "R11 zero count start");
    set_msg(0, 7'h33, 1'b0, 1'b0, 8'd1);
    kick(1);
    expect_cmd(C_START, 8'h66, 1'b1, "R2 busy test start");
    @(negedge clk);
    kick(1);
    expect_quiet(4, "R11 start while busy");
    evt(1'b1, 1'b0, 8'h00);
    expect_cmd(C_STOP, 8'h00, 1'b0, "R6 busy test stop");
    expect_end(1'b0, 0, "R11 busy test");
  endtask

  initial begin
    for (int i = 0; i < 8; i++) set_msg(i, 7'h00, 1'b0, 1'b0, 8'd0);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_write();
    t_read();
    t_chain();
    t_nostart();
    t_addr_nack();
    t_data_nack();
    t_arb();
    t_ignore();
    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule